// File: doc/BRIEF.md
# UART Bit-Rate Strobe Generator

This block derives the bit-rate timing for a serial port from the system clock. It does not produce a second clock. A cascade of dividers turns the system clock into single-cycle enable pulses. The first stage is a gear that sets the instruction cycle length. The second stage is a count-clock prescaler. The third is a programmable compare divider, followed by a fixed halving stage. The last stage is a final divider whose factor depends on the transfer mode and a rate bit.

A two-bit source code can bypass the internal prescaler. In that case, rising edges of an asynchronous external timer strobe drive the compare divider. The external strobe first passes through a synchroniser. The block has two outputs. One strobe marks each bit period in asynchronous mode, with 16x or 64x oversampling already divided out. The other strobe marks each shift step in synchronous mode.

The configuration inputs are held steady by the surrounding logic. The surrounding logic pulses `cfg_wr` whenever it changes them. That pulse restarts every counter in the chain.

Top module: `baud_chain`

## Requirements
- R1: Synchronous active-high `rst` clears every counter and holds both strobes low. The first strobe after reset is released on clock edge P+5, counted from the last edge on which reset was high, where P is the full period in R2 to R6.
- R2: The gear code selects how many system clocks make one instruction cycle: 00 gives 64, 01 gives 16, 10 gives 8, and 11 gives 4.
- R3: The source code selects the count clock as 1, 16 or 64 instruction cycles for codes 00, 01 and 10.
- R4: The compare stage emits one pulse every `cmp_val`+1 count clocks.
- R5: The compare output is always halved. Each strobe is high for exactly one system clock.
- R6: In asynchronous mode (`sync_mode`=0), the final factor is 16 when `rate_sel`=0 and 64 when it is 1. Only `async_tick` pulses. With a 12.5 MHz clock, the fastest gear, source 00, compare 0 and rate 0, the result is 128 clocks per bit, about 97656 bit/s. With rate 1 it is 512 clocks, about 24414 bit/s.
- R7: In synchronous mode (`sync_mode`=1), the final factor is 2 for either value of `rate_sel`. Only `sync_tick` pulses, and the two strobes are never high together.
- R8: Source code 11 replaces the gear and prescaler with the rising edges of `ext_tick`. The edges are counted after a two-flop synchroniser, so the period is the edge spacing times (cmp+1)×2×final.
- R9: A `cfg_wr` pulse clears all counters and both strobes. The first strobe then appears on edge P+5 after the `cfg_wr` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Pulse marking a change to any setting; restarts the chain |
| gear_sel | input | 2 | Instruction-cycle gear code |
| src_sel | input | 2 | Count clock source code |
| cmp_val | input | CMP_W | Compare value; divide by value+1 |
| rate_sel | input | 1 | Oversampling select in asynchronous mode |
| sync_mode | input | 1 | 1 = synchronous transfer mode |
| ext_tick | input | 1 | Asynchronous external timer strobe |
| async_tick | output | 1 | Bit-rate strobe, asynchronous mode |
| sync_tick | output | 1 | Shift strobe, synchronous mode |

## Verification
The assertions assume two things about the inputs. First, `sync_mode` and the other settings change only in the same cycle as a `cfg_wr` pulse. Second, `rst` is driven to a known level from the first edge. The bench keeps to both assumptions. Every change of setting is applied together with a one-cycle `cfg_wr` at a falling edge. The external strobe is a slow square wave that always toggles on falling edges. The bench measures intervals between strobes in system clocks and compares them with the product of the factors, which it computes from the codes.

// File: rtl/baud_pkg.sv
package baud_pkg;
  // Instruction-cycle gear: terminal count (factor - 1)
  function automatic int gear_last(input logic [1:0] code);
    case (code)
      2'b00:   return 63;
      2'b01:   return 15;
      2'b10:   return 7;
      default: return 3;
    endcase
  endfunction

  // Count clock prescaler: terminal count; code 11 is external, prescaler unused
  function automatic int pre_last(input logic [1:0] code);
    case (code)
      2'b01:   return 15;
      2'b10:   return 63;
      default: return 0;
    endcase
  endfunction

  // Final divider: 2 in synchronous mode, 16/64 in asynchronous mode
  function automatic int fin_last(input logic sync_m, input logic rate);
    if (sync_m) return 1;
    return rate ? 63 : 15;
  endfunction

  localparam logic [1:0] SRC_EXT = 2'b11;
endpackage

// File: rtl/bc_div.sv
// Enable-driven divider: one registered tick after (limit+1) enables.
module bc_div #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (en) begin
        if (cnt >= limit) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bc_edge_sync.sv
// Multi-flop synchroniser followed by a rising-edge detector.
module bc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh[0] <= 1'b0;
          else     sh[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh[i] <= 1'b0;
          else     sh[i] <= sh[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= sh[STAGES-1];
  end

  assign rise = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/baud_chain.sv
module baud_chain
  import baud_pkg::*;
#(
  parameter int CMP_W       = 8,
  parameter int GEAR_W      = 6,
  parameter int PRE_W       = 6,
  parameter int FIN_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [1:0]       gear_sel,
  input  logic [1:0]       src_sel,
  input  logic [CMP_W-1:0] cmp_val,
  input  logic             rate_sel,
  input  logic             sync_mode,
  input  logic             ext_tick,
  output logic             async_tick,
  output logic             sync_tick
);
  localparam logic HALF_LAST = 1'b1;

  logic instr_tick, pre_tick, ext_rise, count_tick;
  logic cmp_tick, half_tick, fin_tick;

  logic [GEAR_W-1:0] gear_lim;
  logic [PRE_W-1:0]  pre_lim;
  logic [FIN_W-1:0]  fin_lim;

  assign gear_lim = GEAR_W'(gear_last(gear_sel));
  assign pre_lim  = PRE_W'(pre_last(src_sel));
  assign fin_lim  = FIN_W'(fin_last(sync_mode, rate_sel));

  bc_div #(.W(GEAR_W)) u_gear (
    .clk(clk), .rst(rst), .clr(cfg_wr), .en(1'b1),
    .limit(gear_lim), .tick(instr_tick)
  );

  bc_div #(.W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clr(cfg_wr), .en(instr_tick),
    .limit(pre_lim), .tick(pre_tick)
  );

  bc_edge_sync #(.STAGES(SYNC_STAGES)) u_ext (
    .clk(clk), .rst(rst), .async_in(ext_tick), .rise(ext_rise)
  );

  assign count_tick = (src_sel == SRC_EXT) ? ext_rise : pre_tick;

  bc_div #(.W(CMP_W)) u_cmp (
    .clk(clk), .rst(rst), .clr(cfg_wr), .en(count_tick),
    .limit(cmp_val), .tick(cmp_tick)
  );

  bc_div #(.W(1)) u_half (
    .clk(clk), .rst(rst), .clr(cfg_wr), .en(cmp_tick),
    .limit(HALF_LAST), .tick(half_tick)
  );

  bc_div #(.W(FIN_W)) u_fin (
    .clk(clk), .rst(rst), .clr(cfg_wr), .en(half_tick),
    .limit(fin_lim), .tick(fin_tick)
  );

  always_ff @(posedge clk) begin
    if (rst || cfg_wr) begin
      async_tick <= 1'b0;
      sync_tick  <= 1'b0;
    end else begin
      async_tick <= fin_tick & ~sync_mode;
      sync_tick  <= fin_tick & sync_mode;
    end
  end
endmodule

// File: rtl/baud_chain_chk.sv
module baud_chain_chk (
  input logic clk,
  input logic rst,
  input logic cfg_wr,
  input logic sync_mode,
  input logic async_tick,
  input logic sync_tick
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!async_tick && !sync_tick));

  assert_clear_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (!async_tick && !sync_tick));

  assert_never_both_R7: assert property (@(posedge clk) disable iff (rst)
    !(async_tick && sync_tick));

  assert_async_in_async_R6: assert property (@(posedge clk) disable iff (rst)
    async_tick |-> !$past(sync_mode));

  assert_sync_in_sync_R7: assert property (@(posedge clk) disable iff (rst)
    sync_tick |-> $past(sync_mode));

  assert_async_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    async_tick |=> !async_tick);

  assert_sync_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    sync_tick |=> !sync_tick);
endmodule

bind baud_chain baud_chain_chk u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .sync_mode(sync_mode),
  .async_tick(async_tick), .sync_tick(sync_tick)
);

// File: tb/baud_chain_tb.sv
module baud_chain_tb;
  localparam int EXT_EDGE = 20;  // ext_tick rising-edge spacing in clocks

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [1:0] gear_sel = 2'b11;
  logic [1:0] src_sel = 2'b00;
  logic [7:0] cmp_val = 8'd0;
  logic       rate_sel = 1'b0;
  logic       sync_mode = 1'b0;
  logic       ext_tick = 1'b0;
  logic       async_tick, sync_tick;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      repeat (EXT_EDGE / 2) @(negedge clk);
      ext_tick = ~ext_tick;
    end
  end

  baud_chain u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .gear_sel(gear_sel),
    .src_sel(src_sel), .cmp_val(cmp_val), .rate_sel(rate_sel),
    .sync_mode(sync_mode), .ext_tick(ext_tick),
    .async_tick(async_tick), .sync_tick(sync_tick)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gear_f(input logic [1:0] g);
    case (g) 2'b00: return 64; 2'b01: return 16; 2'b10: return 8; default: return 4; endcase
  endfunction

  function automatic int src_f(input logic [1:0] s);
    case (s) 2'b01: return 16; 2'b10: return 64; default: return 1; endcase
  endfunction

  function automatic int period(input logic [1:0] g, input logic [1:0] s,
                                input int c, input logic r, input logic m);
    int base;
    base = (s == 2'b11) ? EXT_EDGE : gear_f(g) * src_f(s);
    return base * (c + 1) * 2 * (m ? 2 : (r ? 64 : 16));
  endfunction

  // Wait for the selected strobe; returns cycle stamp or -1 on timeout.
  task automatic wait_strobe(input logic m, input int limit, output int stamp,
                             inout int wrong);
    stamp = -1;
    for (int k = 0; k < limit && stamp < 0; k++) begin
      @(negedge clk);
      if ((m ? async_tick : sync_tick)) wrong++;
      if ((m ? sync_tick : async_tick)) stamp = cyc;
    end
  endtask

  // Apply settings with cfg_wr, check first-strobe latency (optional) and n intervals.
  task automatic run(input logic [1:0] g, input logic [1:0] s, input int c,
                     input logic r, input logic m, input int n,
                     input bit chk_lat, input string tag);
    int p, last, t, wrong;
    p = period(g, s, c, r, m);
    wrong = 0;
    @(negedge clk);
    gear_sel = g; src_sel = s; cmp_val = 8'(c); rate_sel = r; sync_mode = m;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    last = cyc;
    for (int i = 0; i <= n; i++) begin
      wait_strobe(m, 2 * p + 40, t, wrong);
      if (t < 0) begin
        check(1'b0, {tag, " strobe timeout"}, -1, p);
        return;
      end
      if (i == 0) begin
        if (chk_lat) check(t - last == p + 5, {"R9 first strobe after cfg_wr ", tag}, t - last, p + 5);
      end else begin
        check(t - last == p, tag, t - last, p);
      end
      last = t;
    end
    check(wrong == 0, {"R7 other strobe stays low ", tag}, wrong, 0);
  endtask

  initial begin
    int t, wrong, p, c0;
    repeat (3) @(negedge clk);
    check(!async_tick && !sync_tick, "R1 outputs low in reset", int'(async_tick | sync_tick), 0);
    rst = 1'b0;

    // R2: each gear, src 00, cmp 0, async rate 0
    for (int g = 0; g < 4; g++) run(2'(g), 2'b00, 0, 1'b0, 1'b0, 2, 1'b1, "R2 gear factor");
    // R6: nominal 97656 and 24414 bit/s settings
    run(2'b11, 2'b00, 0, 1'b0, 1'b0, 3, 1'b1, "R6 async x16");
    run(2'b11, 2'b00, 0, 1'b1, 1'b0, 3, 1'b1, "R6 async x64");
    // R3: prescaler codes
    run(2'b11, 2'b01, 0, 1'b0, 1'b0, 2, 1'b1, "R3 source 16 cycles");
    run(2'b11, 2'b10, 0, 1'b0, 1'b0, 2, 1'b1, "R3 source 64 cycles");
    // R4/R5: compare sweep in synchronous mode
    for (int c = 0; c < 8; c++) run(2'b11, 2'b00, c, 1'b0, 1'b1, 3, 1'b1, "R4 compare plus one");
    run(2'b00, 2'b00, 2, 1'b0, 1'b0, 2, 1'b1, "R5 halving with compare 2");
    // R7: rate bit ignored in synchronous mode
    run(2'b11, 2'b00, 1, 1'b1, 1'b1, 3, 1'b1, "R7 sync rate1 still x2");
    run(2'b01, 2'b01, 1, 1'b0, 1'b1, 2, 1'b1, "R7 sync gear16 src16");
    // R8: external strobe source
    run(2'b00, 2'b11, 1, 1'b0, 1'b1, 3, 1'b0, "R8 external sync");
    run(2'b00, 2'b11, 0, 1'b0, 1'b0, 2, 1'b0, "R8 external async");

    // R1: mid-run reset restarts the chain
    run(2'b11, 2'b00, 0, 1'b0, 1'b0, 1, 1'b1, "R1 before reset");
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(!async_tick && !sync_tick, "R1 outputs low in reset", int'(async_tick | sync_tick), 0);
    rst = 1'b0;
    c0 = cyc;
    wrong = 0;
    p = period(2'b11, 2'b00, 0, 1'b0, 1'b0);
    wait_strobe(1'b0, 2 * p + 40, t, wrong);
    check(t - c0 == p + 5, "R1 first strobe after reset", t - c0, p + 5);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule